// File: doc/BRIEF.md
# PCI Express Link Reset Sequencer

This block turns a set of reset requests into the three resets a PCI Express protocol core needs. The datapath reset clears the datapath state machines. The configuration reset clears the configuration registers that are not sticky. The sticky reset, active low, clears only the sticky registers. The requests are a power-on reset, the fundamental reset pin, and three active-low exit pulses: leaving the L2 low-power state, leaving a hot reset, and the data link coming back up after it went down.

Two static parameters choose the variant. `IS_ROOT` selects root-port behaviour, in which a data-link exit clears the datapath but leaves the configuration registers alone. `HARD_STYLE` selects the hard core style, whose resets must last at least two clock cycles instead of one. Each of the two synchronous resets comes from its own down-counter. A new request reloads the counter, and a reload never shortens a count already running. While the fundamental reset pin is low, both resets stay asserted. After the pin is released they stay asserted for a further `PERST_HOLD` cycles, so the link partner has time to settle before training starts.

Top module: `pcie_rst_seq`

## Requirements
- R1: With `IS_ROOT`=0, a falling edge on any of `l2_exit_n`, `hot_exit_n` or `dl_exit_n` asserts both `dp_rst` and `cfg_rst`, and the two outputs always carry the same value.
- R2: A pulse started by an exit event lasts exactly MIN cycles, where MIN is 1 when `HARD_STYLE`=0 and 2 when `HARD_STYLE`=1. The pulse begins on the third rising clock edge after the edge that first samples the input low.
- R3: With `IS_ROOT`=1, a falling edge on `dl_exit_n` asserts `dp_rst` only and leaves `cfg_rst` low, while falling edges on `l2_exit_n` and `hot_exit_n` assert both. `cfg_rst` is never high while `dp_rst` is low.
- R4: Both resets rise on the third clock edge after `perst_n` is first sampled low. They stay high while the pin is low, and after the pin is released they stay high for exactly `PERST_HOLD` cycles counted from the second edge that samples it high.
- R5: `sticky_rst_n` is low exactly while the synchronized `por_n` or the synchronized `perst_n` is low. Exit events never change it.
- R6: `por_n` low asserts `dp_rst` and `cfg_rst` and pulls `sticky_rst_n` low at once, with no clock edge needed. After release, `sticky_rst_n` rises on the second clock edge and both resets stay high for MIN more cycles.
- R7: An event that arrives while a reset is counting reloads the counter, so a second event extends the pulse. A reload to a shorter length never cuts a longer count that is already running.
- R8: Only falling edges of the exit inputs are events. An input held low gives a single pulse, and its rising edge gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset request, active low, asynchronous assertion |
| perst_n | input | 1 | Fundamental reset pin, active low |
| l2_exit_n | input | 1 | L2 low-power exit pulse, active low |
| hot_exit_n | input | 1 | Hot-reset exit pulse, active low |
| dl_exit_n | input | 1 | Data-link-down exit pulse, active low |
| dp_rst | output | 1 | Datapath state machine reset, active high, synchronous |
| cfg_rst | output | 1 | Non-sticky configuration register reset, active high, synchronous |
| sticky_rst_n | output | 1 | Sticky register reset, active low |

## Verification
Inputs are driven at the falling clock edge. With the edge count at that moment taken as n, an exit pulse shows on the resets from sample n+3 for MIN samples. The fundamental reset pin pulls the sticky output low at sample n+2 and raises the resets at n+3. After release at count m, the sticky output returns at m+2 and the resets stay high through m+1+`PERST_HOLD`. Release of the power-on reset lets the sticky output rise at n+2, and the resets drop after n+1+MIN.

The driver turns each of these offsets into one expected item per cycle, tagged with its absolute cycle number. The monitor compares each item at exactly that cycle's falling edge. Two instances run on the same stimulus: a soft endpoint and a hard root port with a short hold. Every pattern therefore checks both variants at once, and the asynchronous power-on assertion is checked 1 ns after the input changes.

// File: rtl/pcie_rst_seq_pkg.sv
package pcie_rst_seq_pkg;

  // Exit request lanes; index order is used by the per-output masks.
  localparam int unsigned NUM_EXIT  = 3;
  localparam int unsigned EXIT_L2   = 0;
  localparam int unsigned EXIT_HOT  = 1;
  localparam int unsigned EXIT_DL   = 2;
  localparam int unsigned NUM_CHAN  = 2;   // 0: datapath, 1: configuration

  typedef struct packed {
    logic                por;     // synchronized power-on request
    logic                perst;   // synchronized fundamental reset pin
    logic [NUM_EXIT-1:0] exit_f;  // one-cycle falling-edge strobes
  } rst_req_t;

  // Minimum pulse width for the chosen core style.
  function automatic int unsigned min_pulse(input bit hard);
    return hard ? 2 : 1;
  endfunction

  // Which exit strobes may start a given output channel.
  function automatic logic [NUM_EXIT-1:0] chan_mask(input int unsigned chan,
                                                     input bit is_root);
    logic [NUM_EXIT-1:0] m;
    m = '1;
    if (chan == 1 && is_root) m[EXIT_DL] = 1'b0;
    return m;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcie_rst_sync2.sv
module pcie_rst_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;

endmodule

// File: rtl/pcie_rst_fall_det.sv
module pcie_rst_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);

  logic sync_q;
  logic prev_q;

  pcie_rst_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_n),
    .q     (sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q;
  end

  assign fall = prev_q & ~sync_q;

endmodule

// File: rtl/pcie_rst_stretch.sv
module pcie_rst_stretch #(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned MIN_LEN  = 1,
  parameter int unsigned HOLD_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_i,   // level request that asserts the output at once
  input  logic hold_i,    // level request that loads the long hold
  input  logic evt_i,     // request that loads the minimum width
  output logic rst_o
);

  localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_LEN);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_v;
  logic             busy, load, cnt_en;

  always_comb begin
    if (hold_i)     load_v = HOLD_V;
    else if (evt_i) load_v = MIN_V;
    else            load_v = '0;
    busy   = (cnt_q != '0);
    // reload only when it does not shorten the running count
    load   = (load_v != '0) && (load_v >= cnt_q);
    cnt_en = load | busy;
    cnt_d  = load ? load_v : (cnt_q - ONE_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rst_o = force_i | busy;

endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
  import pcie_rst_seq_pkg::*;
#(
  parameter bit          IS_ROOT    = 1'b0,
  parameter bit          HARD_STYLE = 1'b0,
  parameter int unsigned PERST_HOLD = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic perst_n,
  input  logic l2_exit_n,
  input  logic hot_exit_n,
  input  logic dl_exit_n,
  output logic dp_rst,
  output logic cfg_rst,
  output logic sticky_rst_n
);

  localparam int unsigned MIN_LEN = min_pulse(HARD_STYLE);
  localparam int unsigned CNT_W   = $clog2(max_u(PERST_HOLD, MIN_LEN) + 1);

  rst_req_t            req;
  logic                por_ok;
  logic                perst_q;
  logic [NUM_EXIT-1:0] exit_pins_n;
  logic [NUM_CHAN-1:0] rst_vec;

  // Power-on request: asserted asynchronously, released through two stages.
  pcie_rst_sync2 #(.RST_VAL(1'b0)) u_por_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (1'b1),
    .q     (por_ok)
  );

  // Fundamental reset pin; idles released so power-on alone stays short.
  pcie_rst_sync2 #(.RST_VAL(1'b1)) u_perst_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (perst_n),
    .q     (perst_q)
  );

  assign exit_pins_n[EXIT_L2]  = l2_exit_n;
  assign exit_pins_n[EXIT_HOT] = hot_exit_n;
  assign exit_pins_n[EXIT_DL]  = dl_exit_n;

  for (genvar gi = 0; gi < NUM_EXIT; gi++) begin : g_exit
    pcie_rst_fall_det u_fall (
      .clk   (clk),
      .rst_n (por_n),
      .pin_n (exit_pins_n[gi]),
      .fall  (req.exit_f[gi])
    );
  end

  assign req.por   = ~por_ok;
  assign req.perst = ~perst_q;

  for (genvar gc = 0; gc < NUM_CHAN; gc++) begin : g_chan
    localparam logic [NUM_EXIT-1:0] MASK = chan_mask(gc, IS_ROOT);
    logic evt;
    assign evt = req.por | (|(req.exit_f & MASK));

    pcie_rst_stretch #(
      .CNT_W    (CNT_W),
      .MIN_LEN  (MIN_LEN),
      .HOLD_LEN (PERST_HOLD)
    ) u_stretch (
      .clk     (clk),
      .rst_n   (por_n),
      .force_i (req.por),
      .hold_i  (req.perst),
      .evt_i   (evt),
      .rst_o   (rst_vec[gc])
    );
  end

  assign dp_rst       = rst_vec[0];
  assign cfg_rst      = rst_vec[1];
  assign sticky_rst_n = ~(req.por | req.perst);

endmodule

// File: rtl/pcie_rst_seq_chk.sv
module pcie_rst_seq_chk #(
  parameter bit IS_ROOT    = 1'b0,
  parameter bit HARD_STYLE = 1'b0
) (
  input logic clk,
  input logic por_n,
  input logic dp_rst,
  input logic cfg_rst,
  input logic sticky_rst_n
);

  if (!IS_ROOT) begin : g_ep
    AST_EP_OUTPUTS_MATCH: assert property (@(posedge clk) disable iff (!por_n)
      dp_rst == cfg_rst); // R1
  end

  AST_CFG_WITHIN_DP: assert property (@(posedge clk) disable iff (!por_n)
    cfg_rst |-> dp_rst); // R3

  if (HARD_STYLE) begin : g_hard
    AST_DP_MIN_TWO: assert property (@(posedge clk) disable iff (!por_n)
      $rose(dp_rst) |=> dp_rst); // R2
    AST_CFG_MIN_TWO: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cfg_rst) |=> cfg_rst); // R2
  end

  AST_PIN_ASSERTS_BOTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sticky_rst_n) |=> (dp_rst && cfg_rst)); // R4

  AST_STICKY_FREE_FIRST: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sticky_rst_n) |-> (dp_rst && cfg_rst)); // R6

endmodule

bind pcie_rst_seq pcie_rst_seq_chk #(
  .IS_ROOT    (IS_ROOT),
  .HARD_STYLE (HARD_STYLE)
) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .dp_rst       (dp_rst),
  .cfg_rst      (cfg_rst),
  .sticky_rst_n (sticky_rst_n)
);

// File: tb/tb_pcie_rst_seq.sv
`timescale 1ns/100ps
module tb_pcie_rst_seq;

  localparam int HOLD0 = 1024;  // endpoint, soft: MIN 1
  localparam int HOLD1 = 16;    // root port, hard: MIN 2

  typedef struct {
    int         cyc;
    logic [5:0] v;    // {dp0,cfg0,stk0,dp1,cfg1,stk1}
    int         rq;
  } exp_t;

  logic clk = 1'b0;
  logic por_n, perst_n, l2_n, hot_n, dl_n;
  logic dp0, cfg0, stk0, dp1, cfg1, stk1;
  int   cyc = 0;
  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;
  exp_t q[$];
  exp_t e;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pcie_rst_seq dut (
    .clk(clk), .por_n(por_n), .perst_n(perst_n), .l2_exit_n(l2_n),
    .hot_exit_n(hot_n), .dl_exit_n(dl_n),
    .dp_rst(dp0), .cfg_rst(cfg0), .sticky_rst_n(stk0));

  pcie_rst_seq #(.IS_ROOT(1'b1), .HARD_STYLE(1'b1), .PERST_HOLD(HOLD1)) dut_rp (
    .clk(clk), .por_n(por_n), .perst_n(perst_n), .l2_exit_n(l2_n),
    .hot_exit_n(hot_n), .dl_exit_n(dl_n),
    .dp_rst(dp1), .cfg_rst(cfg1), .sticky_rst_n(stk1));

  function automatic string tag(input int rq);
    case (rq)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check_vec(input logic [5:0] exp_v, input int rq, input int at);
    logic [5:0] act;
    act = {dp0, cfg0, stk0, dp1, cfg1, stk1};
    vectors++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s cycle %0d actual %b expected %b", tag(rq), at, act, exp_v);
    end
  endtask

  task automatic push(input int c, input bit d0, input bit c0, input bit s,
                      input bit d1, input bit c1, input int rq);
    exp_t it;
    it.cyc = c;
    it.v   = {d0, c0, s, d1, c1, s};
    it.rq  = rq;
    q.push_back(it);
  endtask

  // Monitor: compare each expected item at its own cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      if (e.cyc != cyc) begin
        vectors++; fails++;
        $display("FAIL %s item for cycle %0d missed at cycle %0d", tag(e.rq), e.cyc, cyc);
      end else begin
        check_vec(e.v, e.rq, cyc);
      end
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic set_exit(input int sel, input logic v);
    case (sel)
      0: l2_n  = v;
      1: hot_n = v;
      default: dl_n = v;
    endcase
  endtask

  task automatic idle(input int k, input int rq);
    int n;
    n = cyc;
    for (int r = 1; r <= k; r++) push(n + r, 0, 0, 1, 0, 0, rq);
    wait_to(n + k);
  endtask

  task automatic por_release();  // R6
    int n;
    n = cyc;
    por_n = 1'b1;
    for (int r = 1; r <= 6; r++)
      push(n + r, r <= 2, r <= 2, r >= 2, r <= 3, r <= 3, 6);
    wait_to(n + 6);
  endtask

  // One-cycle low pulse on an exit input. R1 R2 R3
  task automatic evt_pulse(input int sel, input int rq);
    int n;
    n = cyc;
    set_exit(sel, 1'b0);
    for (int r = 1; r <= 8; r++) begin
      bit h0, h1;
      h0 = (r == 3);
      h1 = (r == 3) || (r == 4);
      push(n + r, h0, h0, 1, h1, h1 && (sel != 2), rq);
    end
    @(negedge clk);
    set_exit(sel, 1'b1);
    wait_to(n + 8);
  endtask

  // Held-low input: one pulse, nothing on the rising edge. R8
  task automatic evt_hold();
    int n;
    n = cyc;
    hot_n = 1'b0;
    for (int r = 1; r <= 16; r++) begin
      bit h0, h1;
      h0 = (r == 3);
      h1 = (r == 3) || (r == 4);
      push(n + r, h0, h0, 1, h1, h1, 8);
    end
    wait_to(n + 10);
    hot_n = 1'b1;
    wait_to(n + 16);
  endtask

  // Two close pulses: second reloads the counter. R7
  task automatic evt_pair();
    int n;
    n = cyc;
    l2_n = 1'b0;
    for (int r = 1; r <= 9; r++) begin
      bit h0, h1;
      h0 = (r == 3) || (r == 5);
      h1 = (r >= 3) && (r <= 6);
      push(n + r, h0, h0, 1, h1, h1, 7);
    end
    @(negedge clk); l2_n = 1'b1;
    @(negedge clk); l2_n = 1'b0;
    @(negedge clk); l2_n = 1'b1;
    wait_to(n + 9);
  endtask

  // Fundamental reset pin held L cycles, then an exit pulse during the hold. R4 R5 R7
  task automatic perst_seq();
    localparam int L = 10;
    int n, rmax;
    n = cyc;
    rmax = L + 1 + HOLD0 + 3;
    perst_n = 1'b0;
    for (int r = 1; r <= rmax; r++) begin
      bit s, h0, h1;
      s  = !(r >= 2 && r <= L + 1);
      h0 = (r >= 3) && (r <= L + 1 + HOLD0);
      h1 = (r >= 3) && (r <= L + 1 + HOLD1);
      push(n + r, h0, h0, s, h1, h1, (r <= L + 2) ? 5 : 4);
    end
    wait_to(n + L);
    perst_n = 1'b1;
    wait_to(n + L + 4);
    l2_n = 1'b0;     // must neither shorten the hold nor touch sticky (R7, R5)
    @(negedge clk);
    l2_n = 1'b1;
    wait_to(n + rmax);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    finish_run();
  end

  initial begin
    por_n = 1'b0; perst_n = 1'b1; l2_n = 1'b1; hot_n = 1'b1; dl_n = 1'b1;
    repeat (2) @(negedge clk);
    check_vec(6'b110110, 6, cyc);        // R6 reset state
    por_release();                       // R6
    idle(4, 5);                          // R5 quiet after release
    evt_pulse(0, 1);                     // R1 R2 L2 exit
    evt_pulse(1, 2);                     // R2 hot exit
    evt_pulse(2, 3);                     // R3 link-down exit, root cfg stays low
    evt_hold();                          // R8
    evt_pair();                          // R7
    perst_seq();                         // R4 R5 R7
    idle(3, 5);
    por_n = 1'b0;                        // R6 asynchronous assertion
    #1;
    check_vec(6'b110110, 6, cyc);
    @(negedge clk);
    por_release();
    idle(3, 6);
    wait_to(cyc + 2);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R4 %0d expected items left, expected 0", q.size());
    end
    finish_run();
  end

endmodule